// File: doc/BRIEF.md
# Edge Counter Bank

This block holds eight 16-bit up counters, one per digital input line. Each line passes through a two-flop synchroniser, and an edge detector feeds its counter. A per-channel bit chooses whether rising or falling edges are counted. Each counter has its own reload value, which it takes on a load command and again when it steps past its all-ones value. Each counter also has a match value, and reaching it can raise a match flag.

A mailbox processor configures the bank through a one-cycle command strobe. The strobe carries an opcode, an 8-bit channel field (a mask, or a channel index in its low bits) and a 16-bit data word. Overflow and match flags are sticky and are cleared by writing ones. A single interrupt line is raised while any flag is set. Any counter can be read at any time through a combinational read port.

Top module: `edge_counter_bank`

## Requirements
- R1: After reset all counters read 0x0000, every reload value is 0x0000, every match value is 0x8000, the enable, edge-select, overflow-enable and match-enable masks are 0, all flags are 0 and `irq` is 0.
- R2: Counter n counts only edges on `line_in[n]`, and the channels are independent. An edge present on the line at clock edge k is counted at clock edge k+2 (two synchroniser flops, then the counter). At most one count is made per clock.
- R3: Opcode 2 writes the edge-select mask from `cmd_sel`. Bit n = 0 makes counter n count rising edges. Bit n = 1 makes it count falling edges.
- R4: Opcode 1 writes the enable mask from `cmd_sel`. A counter whose enable bit is 0 holds its value.
- R5: Opcode 7 loads every counter selected in `cmd_sel` with its own reload value. The load wins over a count on the same counter in the same cycle.
- R6: Opcode 5 writes `cmd_data` as the reload value of the channel whose index is in `cmd_sel[2:0]`. Opcode 6 writes the match value of that channel in the same way.
- R7: A counted edge at 0xFFFF loads the reload value. It also sets that channel's overflow flag if bit n of the overflow-enable mask is 1. Opcode 3 writes the overflow-enable mask from `cmd_sel`.
- R8: When a counted edge gives a new value (including a value reloaded on wrap) equal to the channel's match value, the match flag is set if bit n of the match-enable mask is 1. Opcode 4 writes the match-enable mask from `cmd_sel`.
- R9: Flags stay set until opcode 8 clears the overflow and match flags of the channels selected in `cmd_sel`. An event that sets a flag in the same cycle as its clear leaves the flag set.
- R10: `irq` is 1 exactly when at least one overflow or match flag is set.
- R11: `rd_data` shows the value held by counter `rd_sel` at the start of the cycle, even in a cycle where that counter steps.
- R12: Opcodes 0 and 9 to 15 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_in | input | 8 | Digital input lines, one per counter |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 4 | Command opcode |
| cmd_sel | input | 8 | Channel mask, or channel index in bits 2:0 |
| cmd_data | input | 16 | Reload or match value for opcodes 5 and 6 |
| rd_sel | input | 3 | Counter to read |
| rd_data | output | 16 | Value of the selected counter |
| ovf_flags | output | 8 | Sticky overflow flags |
| match_flags | output | 8 | Sticky match flags |
| irq | output | 1 | OR of all flags |

## Verification
Two pairs of operations can fall on the same clock edge. A load command can meet a counted edge on the same channel. A flag-clear command can meet a wrap that sets that channel's overflow flag. The bench raises a line, waits until the synchronised edge is due at a known clock edge, and issues the command for that edge. It then expects the reload value with no extra count, and the flag still set. A behavioural reference model, compared on every clock, judges the same interplay in every other cycle of the run.

// File: rtl/ecb_pkg.sv
// Shared definitions for the edge counter bank.
// Assumes a 4-bit opcode field on the command port.
package ecb_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_NOP      = 4'd0,
        OP_ENABLE   = 4'd1,
        OP_EDGE     = 4'd2,
        OP_OVF_IE   = 4'd3,
        OP_MATCH_IE = 4'd4,
        OP_RELOAD   = 4'd5,
        OP_MATCH    = 4'd6,
        OP_LOAD     = 4'd7,
        OP_CLEAR    = 4'd8
    } ecb_op_e;

endpackage

// File: rtl/ecb_sync_edge.sv
// Two-flop synchroniser plus one history flop per line. It gives a one-cycle
// edge pulse of the selected polarity.
// Assumes that edge_sel comes from a register, and that input lines change
// slower than the clock.
module ecb_sync_edge #(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] line_in,
    input  logic [NUM_CH-1:0] edge_sel,
    output logic [NUM_CH-1:0] edge_hit
);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_line
        logic meta_q;
        logic sync_q;
        logic hist_q;
        logic rise;
        logic fall;

        // Synchronise the line and keep one cycle of history.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
                hist_q <= 1'b0;
            end else begin
                meta_q <= line_in[g];
                sync_q <= meta_q;
                hist_q <= sync_q;
            end
        end

        // Pick the counted polarity.
        always_comb begin
            rise        = sync_q & ~hist_q;
            fall        = hist_q & ~sync_q;
            edge_hit[g] = edge_sel[g] ? fall : rise;
        end

        // R2: a rising pulse lasts one cycle only.
        a_r2_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
            rise |=> !rise);
        // R3: a falling pulse lasts one cycle only.
        a_r3_single_fall: assert property (@(posedge clk) disable iff (!rst_n)
            fall |=> !fall);
    end

endmodule

// File: rtl/ecb_config.sv
// Configuration store for the bank: masks, reload and match values. It also
// decodes the one-cycle load and clear pulses.
// Assumes cmd_valid is a single-cycle strobe. Undefined opcodes are dropped.
module ecb_config
    import ecb_pkg::*;
#(
    parameter int              NUM_CH      = 8,
    parameter int              CNT_W       = 16,
    parameter logic [CNT_W-1:0] RELOAD_INIT = '0,
    parameter logic [CNT_W-1:0] MATCH_INIT  = CNT_W'(1) << (CNT_W - 1),
    localparam int             IDX_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cmd_valid,
    input  logic [OP_W-1:0]               cmd_op,
    input  logic [NUM_CH-1:0]             cmd_sel,
    input  logic [CNT_W-1:0]              cmd_data,
    output logic [NUM_CH-1:0]             en_mask,
    output logic [NUM_CH-1:0]             edge_mask,
    output logic [NUM_CH-1:0]             ovf_ie,
    output logic [NUM_CH-1:0]             match_ie,
    output logic [NUM_CH-1:0][CNT_W-1:0]  reload_val,
    output logic [NUM_CH-1:0][CNT_W-1:0]  match_val,
    output logic [NUM_CH-1:0]             load_mask,
    output logic [NUM_CH-1:0]             clear_mask
);

    ecb_op_e          op;
    logic [IDX_W-1:0] idx;

    // Decode the opcode and the channel index.
    always_comb begin
        op  = ecb_op_e'(cmd_op);
        idx = cmd_sel[IDX_W-1:0];
    end

    // Mask registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_mask   <= '0;
            edge_mask <= '0;
            ovf_ie    <= '0;
            match_ie  <= '0;
        end else if (cmd_valid) begin
            case (op)
                OP_ENABLE:   en_mask   <= cmd_sel;
                OP_EDGE:     edge_mask <= cmd_sel;
                OP_OVF_IE:   ovf_ie    <= cmd_sel;
                OP_MATCH_IE: match_ie  <= cmd_sel;
                default:     ;
            endcase
        end
    end

    // Per-channel reload and match values, written by index.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_CH; i++) begin
            if (!rst_n) begin
                reload_val[i] <= RELOAD_INIT;
                match_val[i]  <= MATCH_INIT;
            end else if (cmd_valid && idx == IDX_W'(i)) begin
                if (op == OP_RELOAD) reload_val[i] <= cmd_data;
                if (op == OP_MATCH)  match_val[i]  <= cmd_data;
            end
        end
    end

    // Single-cycle action pulses that go to the channels.
    always_comb begin
        load_mask  = (cmd_valid && op == OP_LOAD)  ? cmd_sel : '0;
        clear_mask = (cmd_valid && op == OP_CLEAR) ? cmd_sel : '0;
    end

    // R12: an undefined opcode leaves every mask untouched.
    a_r12_ignore_op: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_op == 4'd0 || cmd_op > 4'd8))
        |=> ($stable(en_mask) && $stable(edge_mask) && $stable(ovf_ie) && $stable(match_ie)));

endmodule

// File: rtl/ecb_channel.sv
// One counter channel. It holds the counter, wraps to the reload value, and
// keeps sticky overflow and match flags.
// Assumes step is a one-cycle pulse. A load beats a step in the same cycle,
// and a set beats a clear.
module ecb_channel #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             step,
    input  logic             load,
    input  logic             clear,
    input  logic             ovf_en,
    input  logic             match_en,
    input  logic [CNT_W-1:0] reload_val,
    input  logic [CNT_W-1:0] match_val,
    output logic [CNT_W-1:0] count,
    output logic             ovf_flag,
    output logic             match_flag
);

    logic [CNT_W-1:0] count_nxt;
    logic             ovf_set;
    logic             match_set;
    logic             at_top;

    // Next count value and flag events.
    always_comb begin
        at_top    = (count == {CNT_W{1'b1}});
        count_nxt = count;
        ovf_set   = 1'b0;
        match_set = 1'b0;
        if (load) begin
            count_nxt = reload_val;
        end else if (enable && step) begin
            count_nxt = at_top ? reload_val : count + 1'b1;
            ovf_set   = at_top && ovf_en;
            match_set = match_en && (count_nxt == match_val);
        end
    end

    // Counter and sticky flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count      <= '0;
            ovf_flag   <= 1'b0;
            match_flag <= 1'b0;
        end else begin
            count      <= count_nxt;
            ovf_flag   <= (ovf_flag & ~clear) | ovf_set;
            match_flag <= (match_flag & ~clear) | match_set;
        end
    end

    // R4: a disabled counter with no load holds its value.
    a_r4_hold_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !load) |=> count == $past(count));
    // R5: a load always lands the reload value.
    a_r5_load_value: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> count == $past(reload_val));
    // R7: a counted step at the top value wraps to the reload value.
    a_r7_wrap_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && enable && step && at_top) |=> count == $past(reload_val));
    // R9: a flag with no clear stays set.
    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !clear) |=> ovf_flag);

endmodule

// File: rtl/edge_counter_bank.sv
// Top of the edge counter bank: the synchroniser and edge detect, the
// configuration store and one counter channel per input line.
// Assumes a single clock domain. The input lines are asynchronous.
module edge_counter_bank
    import ecb_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int CNT_W  = 16,
    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] line_in,
    input  logic              cmd_valid,
    input  logic [OP_W-1:0]   cmd_op,
    input  logic [NUM_CH-1:0] cmd_sel,
    input  logic [CNT_W-1:0]  cmd_data,
    input  logic [IDX_W-1:0]  rd_sel,
    output logic [CNT_W-1:0]  rd_data,
    output logic [NUM_CH-1:0] ovf_flags,
    output logic [NUM_CH-1:0] match_flags,
    output logic              irq
);

    logic [NUM_CH-1:0]            en_mask;
    logic [NUM_CH-1:0]            edge_mask;
    logic [NUM_CH-1:0]            ovf_ie;
    logic [NUM_CH-1:0]            match_ie;
    logic [NUM_CH-1:0][CNT_W-1:0] reload_val;
    logic [NUM_CH-1:0][CNT_W-1:0] match_val;
    logic [NUM_CH-1:0]            load_mask;
    logic [NUM_CH-1:0]            clear_mask;
    logic [NUM_CH-1:0]            edge_hit;
    logic [NUM_CH-1:0][CNT_W-1:0] count_all;

    ecb_sync_edge #(.NUM_CH(NUM_CH)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_in  (line_in),
        .edge_sel (edge_mask),
        .edge_hit (edge_hit)
    );

    ecb_config #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .cmd_sel    (cmd_sel),
        .cmd_data   (cmd_data),
        .en_mask    (en_mask),
        .edge_mask  (edge_mask),
        .ovf_ie     (ovf_ie),
        .match_ie   (match_ie),
        .reload_val (reload_val),
        .match_val  (match_val),
        .load_mask  (load_mask),
        .clear_mask (clear_mask)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        ecb_channel #(.CNT_W(CNT_W)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .enable     (en_mask[g]),
            .step       (edge_hit[g]),
            .load       (load_mask[g]),
            .clear      (clear_mask[g]),
            .ovf_en     (ovf_ie[g]),
            .match_en   (match_ie[g]),
            .reload_val (reload_val[g]),
            .match_val  (match_val[g]),
            .count      (count_all[g]),
            .ovf_flag   (ovf_flags[g]),
            .match_flag (match_flags[g])
        );
    end

    // Read mux on the registered counts.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (rd_sel == IDX_W'(i)) rd_data = count_all[i];
        end
    end

    // Combined interrupt line.
    always_comb begin
        irq = |{ovf_flags, match_flags};
    end

    // R9: a clear with no new event drops the selected overflow flags.
    a_r9_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_mask != '0 && edge_hit == '0) |=> ((ovf_flags & $past(clear_mask)) == '0));

endmodule

// File: tb/test_edge_counter_bank.sv
module test_edge_counter_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  line_in = '0;
    logic        cmd_valid = 1'b0;
    logic [3:0]  cmd_op = '0;
    logic [7:0]  cmd_sel = '0;
    logic [15:0] cmd_data = '0;
    logic [2:0]  rd_sel = '0;
    logic [15:0] rd_data;
    logic [7:0]  ovf_flags;
    logic [7:0]  match_flags;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [15:0] seen [8];

    always #10 clk = ~clk;

    edge_counter_bank i_edge_counter_bank (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_sel(cmd_sel), .cmd_data(cmd_data), .rd_sel(rd_sel),
        .rd_data(rd_data), .ovf_flags(ovf_flags), .match_flags(match_flags), .irq(irq)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference model, written from the requirements.
    logic [15:0] m_cnt [8];
    logic [15:0] m_rel [8];
    logic [15:0] m_mat [8];
    logic [7:0]  m_en, m_edge, m_oie, m_mie, m_ovf, m_mf;
    bit          m_s1 [8];
    bit          m_s2 [8];
    bit          m_s3 [8];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 8; c++) begin
                m_cnt[c] = 16'h0000; m_rel[c] = 16'h0000; m_mat[c] = 16'h8000;
                m_s1[c] = 0; m_s2[c] = 0; m_s3[c] = 0;
            end
            m_en = 0; m_edge = 0; m_oie = 0; m_mie = 0; m_ovf = 0; m_mf = 0;
        end else begin
            for (int c = 0; c < 8; c++) begin
                bit ev, ov, mt, clr;
                logic [15:0] n;
                ev = m_edge[c] ? (m_s3[c] && !m_s2[c]) : (m_s2[c] && !m_s3[c]);
                ov = 0; mt = 0; n = m_cnt[c];
                if (cmd_valid && cmd_op == 4'd7 && cmd_sel[c]) n = m_rel[c];
                else if (m_en[c] && ev) begin
                    if (m_cnt[c] == 16'hFFFF) begin n = m_rel[c]; ov = m_oie[c]; end
                    else n = m_cnt[c] + 16'd1;
                    mt = m_mie[c] && (n == m_mat[c]);
                end
                clr = cmd_valid && cmd_op == 4'd8 && cmd_sel[c];
                m_ovf[c] = (m_ovf[c] && !clr) || ov;
                m_mf[c]  = (m_mf[c] && !clr) || mt;
                m_cnt[c] = n;
                m_s3[c] = m_s2[c]; m_s2[c] = m_s1[c]; m_s1[c] = line_in[c];
            end
            if (cmd_valid) begin
                case (cmd_op)
                    4'd1: m_en = cmd_sel;
                    4'd2: m_edge = cmd_sel;
                    4'd3: m_oie = cmd_sel;
                    4'd4: m_mie = cmd_sel;
                    4'd5: m_rel[cmd_sel[2:0]] = cmd_data;
                    4'd6: m_mat[cmd_sel[2:0]] = cmd_data;
                    default: ;
                endcase
            end
        end
    end

    // Compare against the model on every clock, away from the rising edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(ovf_flags == m_ovf, "R7 R9 ovf_flags vs model", 32'(ovf_flags), 32'(m_ovf));
            chk(match_flags == m_mf, "R8 R9 match_flags vs model", 32'(match_flags), 32'(m_mf));
            chk(irq == (m_ovf != 0 || m_mf != 0), "R10 irq vs model", 32'(irq), 32'(m_ovf != 0 || m_mf != 0));
            for (int c = 0; c < 8; c++) begin
                rd_sel = 3'(c);
                #1;
                chk(rd_data == m_cnt[c], "R2 R11 rd_data vs model", 32'(rd_data), 32'(m_cnt[c]));
                seen[c] = rd_data;
            end
        end
    end

    task automatic cycle();
        @(negedge clk);
        #9;
    endtask

    task automatic send(input logic [3:0] op, input logic [7:0] sel, input logic [15:0] data);
        cmd_valid = 1'b1; cmd_op = op; cmd_sel = sel; cmd_data = data;
        cycle();
        cmd_valid = 1'b0; cmd_op = '0; cmd_sel = '0; cmd_data = '0;
    endtask

    task automatic pulse(input logic [7:0] mask, input int n);
        for (int k = 0; k < n; k++) begin
            line_in = line_in | mask; cycle(); cycle();
            line_in = line_in & ~mask; cycle(); cycle();
        end
        cycle();
    endtask

    task automatic exp_cnt(input int ch, input logic [15:0] exp, input string tag);
        chk(seen[ch] == exp, tag, 32'(seen[ch]), 32'(exp));
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) cycle();
        rst_n = 1'b1;
        cycle(); cycle();
        // R1: reset state
        for (int c = 0; c < 8; c++) exp_cnt(c, 16'h0000, "R1 counter after reset");
        chk(ovf_flags == 0 && match_flags == 0, "R1 flags after reset", 32'({ovf_flags, match_flags}), 0);
        chk(irq == 0, "R1 irq after reset", 32'(irq), 0);

        // R12: undefined opcodes change nothing
        send(4'hF, 8'hFF, 16'hFFFF);
        send(4'h0, 8'hFF, 16'hFFFF);
        send(4'h9, 8'hFF, 16'hFFFF);
        pulse(8'h01, 1);
        exp_cnt(0, 16'h0000, "R12 undefined opcode did not enable ch0");
        chk(ovf_flags == 0 && match_flags == 0, "R12 flags unchanged", 32'({ovf_flags, match_flags}), 0);

        // R4: enable gating
        pulse(8'h04, 2);
        exp_cnt(2, 16'h0000, "R4 disabled counter holds");
        send(4'd1, 8'h24, 16'h0);
        pulse(8'h24, 1);
        pulse(8'h04, 2);
        exp_cnt(2, 16'h0003, "R4 enabled counter counts");
        exp_cnt(5, 16'h0001, "R2 independent channel 5");
        exp_cnt(0, 16'h0000, "R2 channel 0 untouched");

        // R3: falling-edge selection
        send(4'd2, 8'h04, 16'h0);
        line_in[2] = 1'b1;
        repeat (4) cycle();
        exp_cnt(2, 16'h0003, "R3 falling mode ignores rise");
        line_in[2] = 1'b0;
        repeat (3) cycle();
        exp_cnt(2, 16'h0004, "R3 falling mode counts fall");
        pulse(8'h20, 1);
        exp_cnt(5, 16'h0002, "R3 rising mode on ch5");

        // R6 and R5: reload values and the load command
        send(4'd5, 8'd4, 16'h1234);
        send(4'd5, 8'd5, 16'h00AA);
        send(4'd7, 8'h30, 16'h0);
        exp_cnt(4, 16'h1234, "R6 R5 ch4 loaded");
        exp_cnt(5, 16'h00AA, "R6 R5 ch5 loaded");
        exp_cnt(2, 16'h0004, "R5 unselected ch2 kept");
        send(4'd7, 8'h04, 16'h0);
        exp_cnt(2, 16'h0000, "R1 default reload value");
        send(4'd2, 8'h00, 16'h0);

        // R8: match flag, with the default match value
        send(4'd5, 8'd1, 16'h7FFF);
        send(4'd7, 8'h02, 16'h0);
        send(4'd1, 8'h26, 16'h0);
        send(4'd4, 8'h02, 16'h0);
        pulse(8'h02, 1);
        exp_cnt(1, 16'h8000, "R8 ch1 reached match");
        chk(match_flags == 8'h02, "R8 R1 match flag at default 0x8000", 32'(match_flags), 32'h02);
        chk(irq == 1'b1, "R10 irq with match flag", 32'(irq), 1);
        send(4'd6, 8'd5, 16'h00AB);
        pulse(8'h20, 1);
        exp_cnt(5, 16'h00AB, "R8 ch5 at its match value");
        chk(match_flags == 8'h02, "R8 no flag without match enable", 32'(match_flags), 32'h02);

        // R7: wrap and overflow
        send(4'd5, 8'd6, 16'hFFFE);
        send(4'd7, 8'h40, 16'h0);
        send(4'd1, 8'h66, 16'h0);
        send(4'd3, 8'h40, 16'h0);
        pulse(8'h40, 1);
        exp_cnt(6, 16'hFFFF, "R7 ch6 at top");
        chk(ovf_flags == 8'h00, "R7 no overflow before wrap", 32'(ovf_flags), 0);
        pulse(8'h40, 1);
        exp_cnt(6, 16'hFFFE, "R7 ch6 wrapped to reload");
        chk(ovf_flags == 8'h40, "R7 overflow flag set", 32'(ovf_flags), 32'h40);
        send(4'd5, 8'd7, 16'hFFFF);
        send(4'd7, 8'h80, 16'h0);
        send(4'd1, 8'hE6, 16'h0);
        pulse(8'h80, 1);
        exp_cnt(7, 16'hFFFF, "R7 ch7 wrapped to reload");
        chk(ovf_flags == 8'h40, "R7 no flag without overflow enable", 32'(ovf_flags), 32'h40);

        // R9 and R10: write-one-to-clear
        send(4'd8, 8'h40, 16'h0);
        chk(ovf_flags == 8'h00, "R9 overflow cleared", 32'(ovf_flags), 0);
        chk(match_flags == 8'h02, "R9 unselected flag kept", 32'(match_flags), 32'h02);
        chk(irq == 1'b1, "R10 irq still high", 32'(irq), 1);
        send(4'd8, 8'h02, 16'h0);
        chk(irq == 1'b0, "R10 irq low with no flags", 32'(irq), 0);

        // R5: load meets count in the same cycle
        send(4'd1, 8'hF6, 16'h0);
        line_in[4] = 1'b1;
        cycle(); cycle();
        send(4'd7, 8'h10, 16'h0);
        exp_cnt(4, 16'h1234, "R5 load wins over count");
        line_in[4] = 1'b0;
        repeat (3) cycle();

        // R9: a wrap meets a clear in the same cycle
        pulse(8'h40, 1);
        exp_cnt(6, 16'hFFFF, "R7 ch6 at top again");
        line_in[6] = 1'b1;
        cycle(); cycle();
        send(4'd8, 8'h40, 16'h0);
        chk(ovf_flags == 8'h40, "R9 set wins over clear", 32'(ovf_flags), 32'h40);
        exp_cnt(6, 16'hFFFE, "R7 wrap during clear");
        line_in[6] = 1'b0;
        repeat (3) cycle();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule